// File: doc/BRIEF.md
# Device-side L1 entry handshake controller

This block runs the device end of hardware-initiated link power management. While the link is up, it counts consecutive idle cycles. It does this only when software has enabled the deeper low-power link state through a two-bit control field. When the count reaches a programmable limit, the block holds back new outbound transactions. It then asks the far end, over and over, to move the link into L1. Each request is paced by a programmable resend interval and by a grant from the transmit path.

When the far end acknowledges, the block sends a single electrical-idle ordered set and then puts its transmitter into electrical idle. The link then rests in L1. Outbound traffic can appear before the acknowledge; in that case the attempt is dropped so the transaction can go out, and a new attempt needs a fresh idle period. A local exit request, or a wake-up seen from the far end, returns the block to the active state from any point of the sequence.

Top module: `l1_entry_ctrl`

## Requirements
- R1: L1 entry is enabled only when bit 1 of `aspm_ctl` is set (values 2'b10 and 2'b11). With 2'b00 or 2'b01 the block stays in the active state, `link_state` = 0, and `tlp_block` stays low no matter how long the link is idle.
- R2: The idle timer counts consecutive cycles in which `link_idle` = 1 and `tlp_pending` = 0. Any other cycle clears it. With `idle_limit` = N, `tlp_block` first reads high after the (N+1)-th clock edge of an unbroken idle run.
- R3: `tlp_block` rises when entry starts. It stays high through the request, ordered-set and L1 states, and falls only when the block returns to the active state.
- R4: `dllp_req_valid` stays high until `dllp_req_grant` is seen. After a grant it is low for `resend_gap` cycles (a value of 0 acts as 1) and is then raised again. With the grant held high, consecutive requests are therefore `resend_gap`+1 cycles apart. This repeats until an acknowledge arrives.
- R5: An acknowledge (`rx_ack`) during the request phase raises `eios_valid`. It is held until `eios_grant`, so exactly one ordered set is sent. On the next edge `tx_elec_idle` = 1 and `link_state` = 4.
- R6: If `tlp_pending` is seen during the request phase, the block returns to the active state on the next edge with `tlp_block` low. A new attempt then takes a full fresh idle period of `idle_limit`+1 edges.
- R7: When `tlp_pending` and `rx_ack` arrive in the same cycle, the abort wins: the block returns to the active state and sends no ordered set.
- R8: A local `exit_req` in any state other than active returns the block to the active state on the next edge. This releases `tlp_block` and `tx_elec_idle`.
- R9: A far-end wake-up (`rx_exit_seen`) while in L1 returns the block to the active state on the next edge.
- R10: `link_state` encoding: 0 active/idle watch, 1 request pending, 2 waiting to resend, 3 ordered set pending, 4 L1. After reset it reads 0 with every transmit control low.
- R11: In the ordered-set and L1 states `tlp_pending` has no effect; the state and `tx_elec_idle` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aspm_ctl | input | 2 | Link power control field; bit 1 enables L1 entry |
| idle_limit | input | IDLE_W | Idle cycles required before entry |
| resend_gap | input | GAP_W | Cycles between a granted request and the next one |
| link_idle | input | 1 | High when no link activity is seen this cycle |
| tlp_pending | input | 1 | Outbound transaction waiting to be sent |
| rx_ack | input | 1 | Strobe: acknowledge DLLP received |
| rx_exit_seen | input | 1 | Strobe: far end has started L1 exit |
| exit_req | input | 1 | Local request to leave low power |
| dllp_req_valid | output | 1 | Request to transmit the L1 request DLLP |
| dllp_req_grant | input | 1 | Transmit path accepts the DLLP this cycle |
| eios_valid | output | 1 | Request to transmit the electrical-idle ordered set |
| eios_grant | input | 1 | Transmit path accepts the ordered set this cycle |
| tlp_block | output | 1 | Blocks new outbound transactions |
| tx_elec_idle | output | 1 | Drives the transmitter into electrical idle |
| link_state | output | 3 | Current state, encoded as in R10 |

## Verification
The hardest case to reach is a collision inside the short window between a granted request and the acknowledge. Examples are an acknowledge landing in the same cycle as a new pending transaction, or an exit while the ordered set is still waiting for its grant. The stimulus reaches these windows by polling `link_state` each cycle after raising the idle condition and injecting the colliding inputs once the wanted state shows. It also holds a grant low to freeze the block in the request or ordered-set state. A scoreboard holds the expected order of DLLP and ordered-set handshakes, and it also catches any extra or missing transmission in those races.

// File: rtl/l1e_pkg.sv
package l1e_pkg;

    typedef enum logic [2:0] {
        ST_L0_WATCH  = 3'd0,
        ST_REQ_SEND  = 3'd1,
        ST_REQ_WAIT  = 3'd2,
        ST_EIOS_SEND = 3'd3,
        ST_L1        = 3'd4
    } l1e_state_e;

    typedef struct packed {
        l1e_state_e state;
    } l1e_fsm_t;

endpackage

// File: rtl/l1e_idle_timer.sv
module l1e_idle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         busy,
    input  logic [W-1:0] limit,
    output logic         reached
);
    localparam logic [W-1:0] SAT = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable || busy) begin
            cnt_d = '0;
        end else if (cnt_q != SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign reached = enable && !busy && (cnt_q >= limit);

    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_q == '0)); // R2

    AST_IDLE_RUN_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && limit != '0) |-> $past(enable && !busy)); // R2

endmodule

// File: rtl/l1e_gap_timer.sv
module l1e_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] gap,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] eff_gap;
    logic [W:0]   next_ext;

    assign eff_gap  = (gap == '0) ? {{(W-1){1'b0}}, 1'b1} : gap;
    assign next_ext = {1'b0, cnt_q} + 1'b1;
    assign expire   = run && (next_ext >= {1'b0, eff_gap});

    always_comb begin
        cnt_d = '0;
        if (run && !expire) begin
            cnt_d = next_ext[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < eff_gap)); // R4

    AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/l1_entry_ctrl.sv
module l1_entry_ctrl #(
    parameter int IDLE_W = 16,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        aspm_ctl,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic [GAP_W-1:0]  resend_gap,
    input  logic              link_idle,
    input  logic              tlp_pending,
    input  logic              rx_ack,
    input  logic              rx_exit_seen,
    input  logic              exit_req,
    output logic              dllp_req_valid,
    input  logic              dllp_req_grant,
    output logic              eios_valid,
    input  logic              eios_grant,
    output logic              tlp_block,
    output logic              tx_elec_idle,
    output logic [2:0]        link_state
);
    import l1e_pkg::*;

    localparam int L1_EN_BIT = 1;

    l1e_fsm_t fsm_d, fsm_q;

    logic l1_enabled;
    logic exit_any;
    logic idle_run;
    logic idle_busy;
    logic idle_reached;
    logic gap_run;
    logic gap_expire;
    logic in_request;

    assign l1_enabled = aspm_ctl[L1_EN_BIT];
    assign exit_any   = exit_req | rx_exit_seen;
    assign idle_run   = (fsm_q.state == ST_L0_WATCH) && l1_enabled;
    assign idle_busy  = !link_idle || tlp_pending;
    assign gap_run    = (fsm_q.state == ST_REQ_WAIT);
    assign in_request = (fsm_q.state == ST_REQ_SEND) || (fsm_q.state == ST_REQ_WAIT);

    l1e_idle_timer #(
        .W (IDLE_W)
    ) idle_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (idle_run),
        .busy    (idle_busy),
        .limit   (idle_limit),
        .reached (idle_reached)
    );

    l1e_gap_timer #(
        .W (GAP_W)
    ) gap_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (gap_run),
        .gap    (resend_gap),
        .expire (gap_expire)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_L0_WATCH: begin
                if (idle_run && idle_reached) begin
                    fsm_d.state = ST_REQ_SEND;
                end
            end
            ST_REQ_SEND: begin
                if (exit_any || tlp_pending) begin
                    fsm_d.state = ST_L0_WATCH;
                end else if (rx_ack) begin
                    fsm_d.state = ST_EIOS_SEND;
                end else if (dllp_req_grant) begin
                    fsm_d.state = ST_REQ_WAIT;
                end
            end
            ST_REQ_WAIT: begin
                if (exit_any || tlp_pending) begin
                    fsm_d.state = ST_L0_WATCH;
                end else if (rx_ack) begin
                    fsm_d.state = ST_EIOS_SEND;
                end else if (gap_expire) begin
                    fsm_d.state = ST_REQ_SEND;
                end
            end
            ST_EIOS_SEND: begin
                if (exit_any) begin
                    fsm_d.state = ST_L0_WATCH;
                end else if (eios_grant) begin
                    fsm_d.state = ST_L1;
                end
            end
            ST_L1: begin
                if (exit_any) begin
                    fsm_d.state = ST_L0_WATCH;
                end
            end
            default: begin
                fsm_d.state = ST_L0_WATCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_L0_WATCH;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign dllp_req_valid = (fsm_q.state == ST_REQ_SEND);
    assign eios_valid     = (fsm_q.state == ST_EIOS_SEND);
    assign tx_elec_idle   = (fsm_q.state == ST_L1);
    assign tlp_block      = (fsm_q.state != ST_L0_WATCH);
    assign link_state     = fsm_q.state;

    AST_NO_ENTRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 3'd0 && !aspm_ctl[L1_EN_BIT]) |=> (link_state == 3'd0)); // R1

    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_block && !exit_any && !tlp_pending) |=> tlp_block); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dllp_req_valid && !dllp_req_grant && !exit_any && !tlp_pending && !rx_ack)
        |=> dllp_req_valid); // R4

    AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dllp_req_valid, eios_valid, tx_elec_idle})); // R4

    AST_ONE_EIOS: assert property (@(posedge clk) disable iff (!rst_n)
        (eios_valid && eios_grant && !exit_any) |=> (!eios_valid && tx_elec_idle)); // R5

    AST_ABORT_ON_TLP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_request && tlp_pending && !exit_any) |=> (link_state == 3'd0 && !tlp_block)); // R6

    AST_EXIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req && link_state != 3'd0) |=> (link_state == 3'd0 && !tx_elec_idle)); // R8

    AST_L1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_elec_idle && !exit_any) |=> tx_elec_idle); // R11

endmodule

// File: tb/l1_entry_ctrl_tb_top.sv
module l1_entry_ctrl_tb_top;

    localparam int IW    = 16;
    localparam int GW    = 8;
    localparam int LIMIT = 4;
    localparam int GAP   = 3;
    localparam int EV_DLLP = 1;
    localparam int EV_EIOS = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    aspm_ctl;
    logic [IW-1:0] idle_limit;
    logic [GW-1:0] resend_gap;
    logic          link_idle, tlp_pending, rx_ack, rx_exit_seen, exit_req;
    logic          dllp_req_valid, dllp_req_grant;
    logic          eios_valid, eios_grant;
    logic          tlp_block, tx_elec_idle;
    logic [2:0]    link_state;

    int checks = 0;
    int errors = 0;
    int cyc_no = 0;
    int dllp_cnt = 0;
    int dllp_t_last = 0;
    int dllp_t_prev = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    l1_entry_ctrl #(.IDLE_W(IW), .GAP_W(GW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .aspm_ctl       (aspm_ctl),
        .idle_limit     (idle_limit),
        .resend_gap     (resend_gap),
        .link_idle      (link_idle),
        .tlp_pending    (tlp_pending),
        .rx_ack         (rx_ack),
        .rx_exit_seen   (rx_exit_seen),
        .exit_req       (exit_req),
        .dllp_req_valid (dllp_req_valid),
        .dllp_req_grant (dllp_req_grant),
        .eios_valid     (eios_valid),
        .eios_grant     (eios_grant),
        .tlp_block      (tlp_block),
        .tx_elec_idle   (tx_elec_idle),
        .link_state     (link_state)
    );

    function automatic void check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    function automatic void sb_take(int kind);
        if (exp_q.size() == 0) begin
            check_eq("R4/R5", "unexpected transmit handshake", kind, 0);
        end else begin
            check_eq("R4/R5", "transmit handshake order", kind, exp_q.pop_front());
        end
    endfunction

    // monitor: samples at the falling edge, inputs change 1 ns later
    always @(negedge clk) begin
        cyc_no++;
        if (rst_n) begin
            if (dllp_req_valid && dllp_req_grant) begin
                dllp_cnt++;
                dllp_t_prev = dllp_t_last;
                dllp_t_last = cyc_no;
                sb_take(EV_DLLP);
            end
            if (eios_valid && eios_grant) begin
                sb_take(EV_EIOS);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic edges_to_block(output int n);
        n = 0;
        while (!tlp_block && n < 200) begin
            cyc(1);
            n++;
        end
    endtask

    task automatic wait_state(int s);
        int guard = 0;
        while (int'(link_state) != s && guard < 200) begin
            cyc(1);
            guard++;
        end
    endtask

    initial begin
        int n;
        rst_n = 1'b0;
        aspm_ctl = 2'b00;
        idle_limit = IW'(LIMIT);
        resend_gap = GW'(GAP);
        link_idle = 1'b0; tlp_pending = 1'b0; rx_ack = 1'b0;
        rx_exit_seen = 1'b0; exit_req = 1'b0;
        dllp_req_grant = 1'b0; eios_grant = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R10 reset state
        check_eq("R10", "state after reset", int'(link_state), 0);
        check_eq("R10", "transmit controls after reset",
                 int'({dllp_req_valid, eios_valid, tx_elec_idle, tlp_block}), 0);

        // R1 disabled encodings
        aspm_ctl = 2'b01; link_idle = 1'b1;
        cyc(20);
        check_eq("R1", "state with ctl=01", int'(link_state), 0);
        check_eq("R1", "block with ctl=01", int'(tlp_block), 0);
        aspm_ctl = 2'b00;
        cyc(20);
        check_eq("R1", "block with ctl=00", int'(tlp_block), 0);

        // R2 idle period with ctl=10, grant held low
        link_idle = 1'b0; aspm_ctl = 2'b10;
        cyc(2);
        link_idle = 1'b1;
        edges_to_block(n);
        check_eq("R2", "edges until block", n, LIMIT + 1);
        // R4 request held while grant is low
        cyc(5);
        check_eq("R4", "request held without grant", int'(dllp_req_valid), 1);
        check_eq("R4", "state held without grant", int'(link_state), 1);
        exit_req = 1'b1; link_idle = 1'b0;
        cyc(1);
        exit_req = 1'b0;
        check_eq("R8", "state after exit in request", int'(link_state), 0);
        check_eq("R8", "block after exit in request", int'(tlp_block), 0);

        // R2 interrupted idle run, ctl=11
        aspm_ctl = 2'b11;
        link_idle = 1'b1;
        cyc(LIMIT - 1);
        link_idle = 1'b0;
        cyc(1);
        check_eq("R2", "block after broken run", int'(tlp_block), 0);
        link_idle = 1'b1;
        edges_to_block(n);
        check_eq("R2", "edges after restart", n, LIMIT + 1);
        exit_req = 1'b1; link_idle = 1'b0;
        cyc(1);
        exit_req = 1'b0;
        cyc(1);

        // R4/R5 resend and full entry
        dllp_req_grant = 1'b1;
        dllp_cnt = 0;
        exp_q.push_back(EV_DLLP); exp_q.push_back(EV_DLLP); exp_q.push_back(EV_DLLP);
        exp_q.push_back(EV_EIOS);
        link_idle = 1'b1;
        for (int g = 0; g < 200 && dllp_cnt < 3; g++) cyc(1);
        check_eq("R4", "resend spacing", dllp_t_last - dllp_t_prev, GAP + 1);
        rx_ack = 1'b1;
        cyc(1);
        rx_ack = 1'b0;
        check_eq("R5", "ordered set requested", int'(eios_valid), 1);
        check_eq("R3", "block during ordered set", int'(tlp_block), 1);
        cyc(1);
        check_eq("R5", "state after ordered set", int'(link_state), 4);
        check_eq("R5", "transmitter idle", int'(tx_elec_idle), 1);
        check_eq("R3", "block in L1", int'(tlp_block), 1);
        check_eq("R5", "pending handshakes", exp_q.size(), 0);

        // R11 pending traffic ignored in L1, R9 far-end wake
        link_idle = 1'b0; tlp_pending = 1'b1;
        cyc(2);
        tlp_pending = 1'b0;
        check_eq("R11", "state in L1 with pending", int'(link_state), 4);
        check_eq("R11", "tx idle with pending", int'(tx_elec_idle), 1);
        rx_exit_seen = 1'b1;
        cyc(1);
        rx_exit_seen = 1'b0;
        check_eq("R9", "state after far-end exit", int'(link_state), 0);
        check_eq("R9", "tx idle after far-end exit", int'(tx_elec_idle), 0);
        check_eq("R3", "block released", int'(tlp_block), 0);

        // R6 abort by pending traffic, then fresh idle period
        exp_q.push_back(EV_DLLP);
        link_idle = 1'b1;
        wait_state(2);
        tlp_pending = 1'b1; link_idle = 1'b0;
        cyc(1);
        tlp_pending = 1'b0;
        check_eq("R6", "state after abort", int'(link_state), 0);
        check_eq("R6", "block after abort", int'(tlp_block), 0);
        exp_q.push_back(EV_DLLP);
        link_idle = 1'b1;
        edges_to_block(n);
        check_eq("R6", "edges to re-entry", n, LIMIT + 1);

        // R7 ack and pending traffic together
        wait_state(2);
        rx_ack = 1'b1; tlp_pending = 1'b1;
        cyc(1);
        rx_ack = 1'b0; tlp_pending = 1'b0; link_idle = 1'b0;
        check_eq("R7", "state after collision", int'(link_state), 0);
        check_eq("R7", "no ordered set", int'(eios_valid), 0);
        cyc(2);
        check_eq("R7", "stays active", int'(link_state), 0);

        // R8 exit from L1
        exp_q.push_back(EV_DLLP); exp_q.push_back(EV_EIOS);
        link_idle = 1'b1;
        wait_state(2);
        rx_ack = 1'b1;
        wait_state(4);
        rx_ack = 1'b0; link_idle = 1'b0;
        check_eq("R5", "reached L1 again", int'(link_state), 4);
        exit_req = 1'b1;
        cyc(1);
        exit_req = 1'b0;
        check_eq("R8", "state after local exit", int'(link_state), 0);
        check_eq("R8", "tx idle after local exit", int'(tx_elec_idle), 0);

        // R5/R8 ordered set held without grant, then exit
        eios_grant = 1'b0;
        exp_q.push_back(EV_DLLP);
        link_idle = 1'b1;
        wait_state(2);
        rx_ack = 1'b1;
        wait_state(3);
        rx_ack = 1'b0; link_idle = 1'b0;
        cyc(2);
        check_eq("R5", "ordered set held", int'(eios_valid), 1);
        exit_req = 1'b1;
        cyc(1);
        exit_req = 1'b0;
        check_eq("R8", "state after exit in ordered set", int'(link_state), 0);
        check_eq("R8", "block after exit in ordered set", int'(tlp_block), 0);

        cyc(3);
        check_eq("R4", "scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule